// File: doc/BRIEF.md
# Eight-Channel Sample Buffer Controller

This block collects conversion results from a sampling front end and holds them for a processor. The front end delivers one result at a time as a valid strobe, a three-bit channel tag and a 16-bit value. Each of the eight channels keeps its own 16-entry first-in first-out store. A channel stores a result only when the global enable and its own enable are both set. In single-shot mode it stops after a programmed number of results. In continuous mode it keeps storing until its store is full.

Software reaches the block through a simple register bus. A write takes effect at the clock edge where the write strobe is high. A read returns its data on `bus_rdata` from the edge where the read strobe is high and holds it until the next read. Each channel raises three event bits: level reached, store full and store empty. A per-channel mask selects which of these bits summarise into one bit of a global status word. A global mask then selects which of those bits drive the single interrupt output.

Top module: `mcadc_top`

## Requirements
- R1: After reset every register reads zero, except that channel event bit 2 (empty) reads set. `irq` is low.
- R2: A result whose tag names an enabled channel goes into that channel's store. Reads of the channel data register (channel base + 0x14) return results oldest first in bits 15:0 with bits 31:16 zero. Each such read removes the entry it returns.
- R3: While bit 17 of the global control register (0x004) is clear, no channel stores a result.
- R4: Bit 0 of channel control (channel base + 0x00) enables the channel. A result tagged for a disabled channel leaves that channel's status unchanged.
- R5: With bit 1 of channel control clear (single-shot), a channel stores at most the count held in bits 7:2. A write to channel control clears the stored-total counter, which re-arms the channel.
- R6: With bit 1 of channel control set (continuous), a channel stores results until it holds 16 entries.
- R7: A result that arrives for a full channel is dropped. It sets the lost flag, status bit 0, and the entry count stays at 16.
- R8: Channel status (channel base + 0x08) gives the entry count in bits 8:1 and the stored total since the last control write in bits 16:9.
- R9: A data read on an empty channel returns zero and changes neither count.
- R10: The channel event register (channel base + 0x0C) has bit 0 set while the entry count is at least the nonzero level in channel level-register bits 5:0 (base + 0x04). Bit 1 means full and bit 2 means empty. Writing a one to a bit clears it, unless its condition still holds. The event mask sits at base + 0x10 and uses the same bit positions.
- R11: Global status bit 9+n (register 0x010) is set while channel n has a masked-in event bit set, and a write of one clears it. `irq` is the OR over n of global status bit 9+n AND global mask bit 9+n (register 0x00C).
- R12: Global status bit 3 is set whenever any channel stores a result, and a write of one clears it. This bit never drives `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address; channel n is at 0x800 + 0x20*n |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| smp_valid | input | 1 | A result is present this cycle |
| smp_chan | input | 3 | Channel tag of the result |
| smp_data | input | 16 | Result value |
| irq | output | 1 | Shared interrupt output |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle. They also assume that the tag on `smp_chan` is meaningful only while `smp_valid` is high, and that reset is held for at least one clock edge. The bench drives every bus access and every result in a separate two-cycle slot, starting at a falling edge. It therefore never issues a read and a write together. Results and data reads to the same channel never share a cycle, so the entry counts the bench expects follow one step at a time.

// File: rtl/mcadc_pkg.sv
package mcadc_pkg;
    localparam int NCH       = 8;
    localparam int DEPTH     = 16;
    localparam int DW        = 16;
    localparam int AW        = 12;
    localparam int CH_STRIDE = 32;
    localparam int CHW       = $clog2(NCH);
    localparam int OFFW      = $clog2(CH_STRIDE);

    localparam logic [AW-1:0] A_GCTRL = 12'h004;
    localparam logic [AW-1:0] A_GMASK = 12'h00C;
    localparam logic [AW-1:0] A_GSTAT = 12'h010;
    localparam logic [AW-1:0] CH_BASE = 12'h800;

    localparam logic [OFFW-1:0] OFF_CTRL1 = 5'h00;
    localparam logic [OFFW-1:0] OFF_LEVEL = 5'h04;
    localparam logic [OFFW-1:0] OFF_STAT  = 5'h08;
    localparam logic [OFFW-1:0] OFF_EVT   = 5'h0C;
    localparam logic [OFFW-1:0] OFF_EMASK = 5'h10;
    localparam logic [OFFW-1:0] OFF_DATA  = 5'h14;

    localparam int GEN_BIT = 17;
    localparam int GCH_LSB = 9;
    localparam int AUX_BIT = 3;

    typedef enum logic {MODE_SNAP = 1'b0, MODE_CONT = 1'b1} mode_e;
endpackage

// File: rtl/mcadc_chan.sv
module mcadc_chan
    import mcadc_pkg::*;
#(
    parameter int DEPTH_P = DEPTH,
    parameter int DW_P    = DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            glb_en_i,
    input  logic            push_i,
    input  logic [DW_P-1:0] push_data_i,
    input  logic            wr_ctrl1_i,
    input  logic            wr_level_i,
    input  logic            wr_evt_i,
    input  logic            wr_emask_i,
    input  logic            pop_i,
    input  logic [7:0]      wdata_i,
    output logic [31:0]     ctrl1_o,
    output logic [31:0]     level_o,
    output logic [31:0]     stat_o,
    output logic [31:0]     evt_o,
    output logic [31:0]     emask_o,
    output logic [DW_P-1:0] head_o,
    output logic            empty_o,
    output logic            stored_o,
    output logic            irq_o
);
    localparam int PW = $clog2(DEPTH_P);
    localparam int CW = PW + 1;

    typedef struct packed {
        logic          en;
        mode_e         mode;
        logic [5:0]    rounds;
        logic [5:0]    lvl;
        logic          lost;
        logic [7:0]    total;
        logic [2:0]    evt;
        logic [2:0]    emask;
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } ch_t;

    ch_t chan_d, chan_q;
    logic [DW_P-1:0] mem_q [DEPTH_P];
    logic full, empty, armed, take, store, do_pop;
    logic [2:0] cond;

    always_comb begin
        chan_d = chan_q;
        full   = (chan_q.cnt == CW'(DEPTH_P));
        empty  = (chan_q.cnt == '0);
        armed  = chan_q.en && ((chan_q.mode == MODE_CONT) || (chan_q.total < {2'b00, chan_q.rounds}));
        take   = push_i && glb_en_i && armed;
        store  = take && !full;
        do_pop = pop_i && !empty;
        if (take && full) chan_d.lost = 1'b1;
        if (store) begin
            chan_d.wp = chan_q.wp + 1'b1;
            if (chan_q.total != 8'hFF) chan_d.total = chan_q.total + 8'd1;
        end
        if (do_pop) chan_d.rp = chan_q.rp + 1'b1;
        case ({store, do_pop})
            2'b10:   chan_d.cnt = chan_q.cnt + 1'b1;
            2'b01:   chan_d.cnt = chan_q.cnt - 1'b1;
            default: chan_d.cnt = chan_q.cnt;
        endcase
        if (wr_ctrl1_i) begin
            chan_d.en     = wdata_i[0];
            chan_d.mode   = mode_e'(wdata_i[1]);
            chan_d.rounds = wdata_i[7:2];
            chan_d.total  = '0;
            chan_d.lost   = 1'b0;
        end
        if (wr_level_i) chan_d.lvl   = wdata_i[5:0];
        if (wr_emask_i) chan_d.emask = wdata_i[2:0];
        cond = {empty, full, (chan_q.lvl != 6'd0) && (8'(chan_q.cnt) >= 8'(chan_q.lvl))};
        chan_d.evt = (chan_q.evt & ~(wr_evt_i ? wdata_i[2:0] : 3'b000)) | cond;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chan_q <= '0;
        else        chan_q <= chan_d;
    end

    always_ff @(posedge clk) begin
        if (store) mem_q[chan_q.wp] <= push_data_i;
    end

    assign ctrl1_o  = {24'b0, chan_q.rounds, chan_q.mode, chan_q.en};
    assign level_o  = {26'b0, chan_q.lvl};
    assign stat_o   = {15'b0, chan_q.total, 8'(chan_q.cnt), chan_q.lost};
    assign evt_o    = {29'b0, chan_q.evt};
    assign emask_o  = {29'b0, chan_q.emask};
    assign head_o   = mem_q[chan_q.rp];
    assign empty_o  = empty;
    assign stored_o = store;
    assign irq_o    = |(chan_q.evt & chan_q.emask);

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chan_q.cnt <= CW'(DEPTH_P));
    assert_glb_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en_i |=> chan_q.cnt <= $past(chan_q.cnt));
    assert_lost_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && glb_en_i && chan_q.en && chan_q.mode == MODE_CONT && full && !wr_ctrl1_i) |=> chan_q.lost);
    assert_snap_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_q.mode == MODE_SNAP && chan_q.total >= {2'b00, chan_q.rounds} && !wr_ctrl1_i)
        |=> chan_q.total == $past(chan_q.total));
    assert_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty && !push_i) |=> chan_q.cnt == '0);
endmodule

// File: rtl/mcadc_top.sv
module mcadc_top
    import mcadc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic          smp_valid,
    input  logic [CHW-1:0] smp_chan,
    input  logic [DW-1:0] smp_data,
    output logic          irq
);
    typedef struct packed {
        logic           gen;
        logic [NCH-1:0] gmask;
        logic [NCH-1:0] gstat;
        logic           aux;
        logic [31:0]    rdata;
    } glb_t;

    glb_t glb_d, glb_q;

    logic [AW-1:0]   rel;
    logic            ch_hit;
    logic [CHW-1:0]  ch_sel;
    logic [OFFW-1:0] off;
    logic [31:0]     c_ctrl1 [NCH];
    logic [31:0]     c_level [NCH];
    logic [31:0]     c_stat  [NCH];
    logic [31:0]     c_evt   [NCH];
    logic [31:0]     c_emask [NCH];
    logic [DW-1:0]   c_head  [NCH];
    logic [NCH-1:0]  c_empty, c_stored, ch_irq;
    logic [31:0]     rd_mux;
    logic            unused_bits;

    assign rel    = bus_addr - CH_BASE;
    assign ch_hit = (bus_addr >= CH_BASE) && (rel < AW'(NCH * CH_STRIDE));
    assign ch_sel = rel[OFFW +: CHW];
    assign off    = bus_addr[OFFW-1:0];
    assign unused_bits = ^{bus_wdata[31:18], bus_wdata[8]};

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        logic sel;
        assign sel = ch_hit && (ch_sel == CHW'(n));
        mcadc_chan #(.DEPTH_P(DEPTH), .DW_P(DW)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .glb_en_i   (glb_q.gen),
            .push_i     (smp_valid && (smp_chan == CHW'(n))),
            .push_data_i(smp_data),
            .wr_ctrl1_i (bus_wr && sel && off == OFF_CTRL1),
            .wr_level_i (bus_wr && sel && off == OFF_LEVEL),
            .wr_evt_i   (bus_wr && sel && off == OFF_EVT),
            .wr_emask_i (bus_wr && sel && off == OFF_EMASK),
            .pop_i      (bus_rd && sel && off == OFF_DATA),
            .wdata_i    (bus_wdata[7:0]),
            .ctrl1_o    (c_ctrl1[n]),
            .level_o    (c_level[n]),
            .stat_o     (c_stat[n]),
            .evt_o      (c_evt[n]),
            .emask_o    (c_emask[n]),
            .head_o     (c_head[n]),
            .empty_o    (c_empty[n]),
            .stored_o   (c_stored[n]),
            .irq_o      (ch_irq[n])
        );
    end

    always_comb begin
        glb_d  = glb_q;
        rd_mux = '0;
        if (bus_addr == A_GCTRL)      rd_mux[GEN_BIT] = glb_q.gen;
        else if (bus_addr == A_GMASK) rd_mux[GCH_LSB +: NCH] = glb_q.gmask;
        else if (bus_addr == A_GSTAT) begin
            rd_mux[GCH_LSB +: NCH] = glb_q.gstat;
            rd_mux[AUX_BIT]        = glb_q.aux;
        end else if (ch_hit) begin
            case (off)
                OFF_CTRL1: rd_mux = c_ctrl1[ch_sel];
                OFF_LEVEL: rd_mux = c_level[ch_sel];
                OFF_STAT:  rd_mux = c_stat[ch_sel];
                OFF_EVT:   rd_mux = c_evt[ch_sel];
                OFF_EMASK: rd_mux = c_emask[ch_sel];
                OFF_DATA:  rd_mux = c_empty[ch_sel] ? 32'h0 : {{(32-DW){1'b0}}, c_head[ch_sel]};
                default:   rd_mux = '0;
            endcase
        end
        if (bus_rd) glb_d.rdata = rd_mux;
        if (bus_wr && bus_addr == A_GCTRL) glb_d.gen   = bus_wdata[GEN_BIT];
        if (bus_wr && bus_addr == A_GMASK) glb_d.gmask = bus_wdata[GCH_LSB +: NCH];
        glb_d.gstat = (glb_q.gstat & ~((bus_wr && bus_addr == A_GSTAT) ? bus_wdata[GCH_LSB +: NCH] : '0)) | ch_irq;
        glb_d.aux   = (glb_q.aux & ~(bus_wr && bus_addr == A_GSTAT && bus_wdata[AUX_BIT])) | (|c_stored);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) glb_q <= '0;
        else        glb_q <= glb_d;
    end

    assign bus_rdata = glb_q.rdata;
    assign irq       = |(glb_q.gstat & glb_q.gmask);

    assert_gstat_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((glb_q.gstat & ~$past(glb_q.gstat)) & ~$past(ch_irq)) == '0);
    assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && ch_hit && off == OFF_DATA && c_empty[ch_sel]) |=> bus_rdata == 32'h0);
    assert_aux_origin_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(glb_q.aux) |-> $past(|c_stored));
endmodule

// File: tb/mcadc_top_tb.sv
module mcadc_top_tb;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        smp_valid = 1'b0;
    logic [2:0]  smp_chan = '0;
    logic [15:0] smp_data = '0;
    logic        irq;

    int n_chk = 0, n_fail = 0;

    always #(PERIOD/2) clk = ~clk;

    mcadc_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_data(smp_data), .irq(irq)
    );

    typedef struct packed {
        logic [1:0]  op;   // 0 write, 1 read and compare, 2 push result
        logic [11:0] addr; // for push: channel tag in bits 2:0
        logic [31:0] val;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 12'h004, 32'h0,      4'd1},  // R1 global control clear
        '{2'd1, 12'h010, 32'h0,      4'd1},  // R1 global status clear
        '{2'd1, 12'h80C, 32'h4,      4'd10}, // R10 empty event at reset
        '{2'd0, 12'h004, 32'h20000,  4'd3},  // R3 global enable on
        '{2'd0, 12'h800, 32'h3,      4'd6},  // R6 ch0 continuous, enabled
        '{2'd2, 12'h000, 32'h1234,   4'd2},  // R2
        '{2'd2, 12'h000, 32'hABCD,   4'd2},  // R2
        '{2'd2, 12'h001, 32'h5555,   4'd4},  // R4 ch1 disabled
        '{2'd1, 12'h808, 32'h404,    4'd8},  // R8 count 2, total 2
        '{2'd1, 12'h828, 32'h0,      4'd4},  // R4 ch1 untouched
        '{2'd1, 12'h814, 32'h1234,   4'd2},  // R2 oldest first
        '{2'd1, 12'h814, 32'hABCD,   4'd2},  // R2
        '{2'd1, 12'h814, 32'h0,      4'd9},  // R9 empty read
        '{2'd1, 12'h808, 32'h400,    4'd9},  // R9 counts kept
        '{2'd0, 12'h004, 32'h0,      4'd3},  // R3 global enable off
        '{2'd2, 12'h000, 32'h7777,   4'd3},  // R3 dropped
        '{2'd1, 12'h808, 32'h400,    4'd3},  // R3 count unchanged
        '{2'd1, 12'h004, 32'h0,      4'd3}   // R3 readback
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic push(input logic [2:0] c, input logic [15:0] v);
        @(negedge clk); smp_valid = 1'b1; smp_chan = c; smp_data = v;
        @(negedge clk); smp_valid = 1'b0;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 150000);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] r;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        check("R1 irq", {31'b0, irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                2'd0: bus_write(VEC[i].addr, VEC[i].val);
                2'd1: begin
                    bus_read(VEC[i].addr, r);
                    check($sformatf("R%0d vector %0d", VEC[i].req, i), r, VEC[i].val);
                end
                default: push(VEC[i].addr[2:0], VEC[i].val[15:0]);
            endcase
        end

        bus_write(12'h004, 32'h20000);
        // R5 single-shot with rounds 3 on ch3
        bus_write(12'h860, 32'h0D);
        for (int i = 0; i < 5; i++) push(3'd3, 16'h300 + 16'(i));
        bus_read(12'h868, r);
        check("R5 stop after rounds", r, 32'h606);
        bus_write(12'h860, 32'h0D);
        push(3'd3, 16'h3AA);
        bus_read(12'h868, r);
        check("R5 rearm by control write", r, 32'h208);

        // R6 and R7: continuous ch5 filled past capacity
        bus_write(12'h8A0, 32'h3);
        for (int i = 0; i < 17; i++) push(3'd5, 16'h100 + 16'(i));
        bus_read(12'h8A8, r);
        check("R7 lost flag, count 16", r, 32'h2021);
        bus_read(12'h8B4, r);
        check("R6 first entry", r, 32'h100);
        for (int i = 1; i < 16; i++) bus_read(12'h8B4, r);
        check("R7 last kept entry", r, 32'h10F);
        bus_read(12'h8B4, r);
        check("R9 drained read", r, 32'h0);

        // R10 and R11 on ch6, level 2, level event masked in
        bus_write(12'h010, 32'h1FE08);
        bus_write(12'h00C, 32'h8000);
        bus_write(12'h8C4, 32'h2);
        bus_write(12'h8D0, 32'h1);
        bus_write(12'h8C0, 32'h3);
        push(3'd6, 16'h0001);
        idle(4);
        check("R10 below level no irq", {31'b0, irq}, 32'h0);
        push(3'd6, 16'h0002);
        idle(4);
        check("R11 irq at level", {31'b0, irq}, 32'h1);
        bus_read(12'h8CC, r);
        check("R10 event bits", r, 32'h5);
        bus_read(12'h010, r);
        check("R11 global bit 15", r & 32'h1FE00, 32'h8000);
        check("R12 aux set", r & 32'h8, 32'h8);
        bus_write(12'h00C, 32'h0);
        idle(1);
        check("R11 global mask blocks", {31'b0, irq}, 32'h0);
        bus_write(12'h00C, 32'h8000);
        bus_read(12'h8D4, r);
        bus_read(12'h8D4, r);
        bus_write(12'h8CC, 32'h7);
        bus_write(12'h010, 32'h8000);
        idle(3);
        check("R11 irq cleared", {31'b0, irq}, 32'h0);
        bus_read(12'h010, r);
        check("R11 global bit cleared", r & 32'h1FE00, 32'h0);
        bus_read(12'h8CC, r);
        check("R10 only empty remains", r, 32'h4);

        // R12 aux clears and never drives irq
        bus_write(12'h010, 32'h8);
        bus_read(12'h010, r);
        check("R12 aux cleared", r & 32'h8, 32'h0);
        bus_write(12'h00C, 32'h1FE08);
        push(3'd0, 16'h4242);
        idle(3);
        bus_read(12'h010, r);
        check("R12 aux set by store", r & 32'h8, 32'h8);
        check("R12 aux not in irq", {31'b0, irq}, 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule